// File: doc/BRIEF.md
# Serial Control Word Receiver

This block takes 8-bit control words from a host over three wires: a data line, a shift clock and a latch strobe. All three wires are asynchronous to the system clock. Each wire passes through a two-flop synchroniser, and the block finds rising edges in the system clock domain. On each rising shift-clock edge the block takes one data bit, least significant bit first. On a rising latch edge it copies the assembled word into one of two holding registers. The top bit of the word picks the register. One register holds a 7-bit attenuation target. The other holds the mode flags: a two-bit bass-boost code, a de-emphasis enable, a mono enable and a channel pick.

From these registers the block drives the decoded controls. It also drives a routing pair that says which source channel feeds each output, and a boost status flag. A select pin switches the control source to direct parallel pins. While that pin is high, the outputs follow the pins and the serial registers have no effect on the outputs.

Top module: `ctl_word_rx`

## Requirements
- R1: Each rising edge of `host_clk` shifts in one bit from `host_dat`. The first bit shifted is word bit 0 and the eighth is bit 7. Edges of `host_clk` with `host_lat` low change no output.
- R2: On a rising edge of `host_lat`, a word with bit 7 = 0 loads bits 6..0 into `att_target`, with bit 0 as the least significant bit.
- R3: On a rising edge of `host_lat`, a word with bit 7 = 1 loads the mode flags from fixed positions: bass code from bits 1..0, de-emphasis from bit 2, mono from bit 3 and channel pick from bit 4. Bits 6..5 are ignored.
- R4: A mode word leaves `att_target` unchanged, and an attenuation word leaves every mode flag unchanged.
- R5: Source encoding is 0 = left channel, 1 = right channel. With mono off, `out_l_src`=0 and `out_r_src`=1. With mono on and channel pick 1, both outputs are 1. With mono on and channel pick 0, both outputs are 0.
- R6: `boost_active` is 0 when `bass_mode` is 2'b00 (flat) and 1 for every other code.
- R7: While `par_sel` is 1, the outputs show the following: `att_target`=127, `bass_mode`=`pin_bb`, `deemph_on`=`pin_deem`, and stereo routing. Serial words latched during this time have no effect on the outputs.
- R8: Serial words latched while `par_sel` is 1 are still stored. After `par_sel` returns to 0, the outputs show the stored register contents.
- R9: After reset, `att_target` is 127, every mode flag is 0 and routing is stereo.
- R10: When `host_lat` rises just before system clock edge k, the latched value first appears at the outputs after edge k+2. It is not visible after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_sel | input | 1 | 1 = controls come from the parallel pins |
| pin_bb | input | 2 | Parallel bass-boost code |
| pin_deem | input | 1 | Parallel de-emphasis enable |
| host_dat | input | 1 | Serial data from the host |
| host_clk | input | 1 | Serial shift clock from the host |
| host_lat | input | 1 | Latch strobe from the host |
| att_target | output | 7 | Attenuation target (127 = full level) |
| bass_mode | output | 2 | Bass-boost code (00 = flat) |
| deemph_on | output | 1 | De-emphasis enable |
| out_l_src | output | 1 | Source feeding the left output (0 = L, 1 = R) |
| out_r_src | output | 1 | Source feeding the right output (0 = L, 1 = R) |
| boost_active | output | 1 | High when bass boost is in any non-flat mode |

## Verification
The assertions assume that each host wire holds every level for at least two system clocks. Under that assumption each synchronised edge is seen exactly once. They also assume that data is stable across its shift edge, and that a latch strobe never rises in the same system cycle as a shift edge. The stimulus holds each level for three system clocks, changes data only while the shift clock is low, and pulses the latch only after the shift clock has been low for several cycles. The parallel pins change only at falling system edges.

// File: rtl/ctl_word_rx.sv
module ctl_word_rx #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               par_sel,
  input  logic [1:0]         pin_bb,
  input  logic               pin_deem,
  input  logic               host_dat,
  input  logic               host_clk,
  input  logic               host_lat,
  output logic [FRAME_W-2:0] att_target,
  output logic [1:0]         bass_mode,
  output logic               deemph_on,
  output logic               out_l_src,
  output logic               out_r_src,
  output logic               boost_active
);
  localparam int ATT_W   = FRAME_W - 1;
  localparam int SEL_BIT = FRAME_W - 1;
  localparam logic [ATT_W-1:0] ATT_FULL = {ATT_W{1'b1}};
  localparam int BB_LO = 0;
  localparam int DEEM_BIT = 2;
  localparam int MONO_BIT = 3;
  localparam int CSEL_BIT = 4;

  logic [1:0] dat_s, clk_s, lat_s;
  logic clk_d, lat_d;
  logic clk_rise, lat_rise;
  logic [FRAME_W-1:0] sr;
  logic [ATT_W-1:0] att_q;
  logic [1:0] bb_q;
  logic deem_q, mono_q, csel_q;
  logic par_q, pdeem_q;
  logic [1:0] pbb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_s <= '0;
      clk_s <= '0;
      lat_s <= '0;
      clk_d <= 1'b0;
      lat_d <= 1'b0;
    end else begin
      dat_s <= {dat_s[0], host_dat};
      clk_s <= {clk_s[0], host_clk};
      lat_s <= {lat_s[0], host_lat};
      clk_d <= clk_s[1];
      lat_d <= lat_s[1];
    end
  end

  assign clk_rise = clk_s[1] & ~clk_d;
  assign lat_rise = lat_s[1] & ~lat_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else if (clk_rise) sr <= {dat_s[1], sr[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att_q  <= ATT_FULL;
      bb_q   <= 2'b00;
      deem_q <= 1'b0;
      mono_q <= 1'b0;
      csel_q <= 1'b0;
    end else if (lat_rise) begin
      if (!sr[SEL_BIT]) begin
        att_q <= sr[ATT_W-1:0];
      end else begin
        bb_q   <= sr[BB_LO+1:BB_LO];
        deem_q <= sr[DEEM_BIT];
        mono_q <= sr[MONO_BIT];
        csel_q <= sr[CSEL_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q   <= 1'b0;
      pbb_q   <= 2'b00;
      pdeem_q <= 1'b0;
    end else begin
      par_q   <= par_sel;
      pbb_q   <= pin_bb;
      pdeem_q <= pin_deem;
    end
  end

  assign att_target   = par_q ? ATT_FULL : att_q;
  assign bass_mode    = par_q ? pbb_q : bb_q;
  assign deemph_on    = par_q ? pdeem_q : deem_q;
  assign out_l_src    = ~par_q & mono_q & csel_q;
  assign out_r_src    = par_q | ~mono_q | csel_q;
  assign boost_active = |bass_mode;

  // R1
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clk_rise) |-> sr[FRAME_W-2:0] == $past(sr[FRAME_W-1:1]));
  // R1
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clk_rise) |-> $stable(sr));
  // R2
  att_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(att_q) |-> $past(lat_rise) && !$past(sr[SEL_BIT]));
  // R3
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({bb_q, deem_q, mono_q, csel_q}) |-> $past(lat_rise) && $past(sr[SEL_BIT]));
  // R7
  par_att_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(par_sel) |-> att_target == ATT_FULL && bass_mode == $past(pin_bb));
endmodule

// File: tb/sim_ctl_word_rx.sv
module sim_ctl_word_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic par_sel = 1'b0, pin_deem = 1'b0, host_dat = 1'b0, host_clk = 1'b0, host_lat = 1'b0;
  logic [1:0] pin_bb = 2'b00;
  logic [6:0] att_target;
  logic [1:0] bass_mode;
  logic deemph_on, out_l_src, out_r_src, boost_active;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  ctl_word_rx #(.FRAME_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .par_sel(par_sel), .pin_bb(pin_bb), .pin_deem(pin_deem),
    .host_dat(host_dat), .host_clk(host_clk), .host_lat(host_lat),
    .att_target(att_target), .bass_mode(bass_mode), .deemph_on(deemph_on),
    .out_l_src(out_l_src), .out_r_src(out_r_src), .boost_active(boost_active));

  // behavioural reference: input history queues, word as an integer
  bit hc[$], hl[$], hd[$];
  int m_word, m_att, m_bb, m_deem, m_mono, m_csel;
  bit m_par, m_pdeem;
  int m_pbb;

  always @(posedge clk) begin
    if (!rst_n) begin
      hc = {0, 0, 0}; hl = {0, 0, 0}; hd = {0, 0, 0};
      m_word = 0; m_att = 127; m_bb = 0; m_deem = 0; m_mono = 0; m_csel = 0;
      m_par = 0; m_pbb = 0; m_pdeem = 0;
    end else begin
      if (hl[1] && !hl[2]) begin
        if (m_word < 128) m_att = m_word;
        else begin
          m_bb = m_word % 4;
          m_deem = (m_word / 4) % 2;
          m_mono = (m_word / 8) % 2;
          m_csel = (m_word / 16) % 2;
        end
      end
      if (hc[1] && !hc[2]) m_word = (m_word / 2) + (hd[1] ? 128 : 0);
      hc.push_front(host_clk); void'(hc.pop_back());
      hl.push_front(host_lat); void'(hl.pop_back());
      hd.push_front(host_dat); void'(hd.pop_back());
      m_par = par_sel; m_pbb = pin_bb; m_pdeem = pin_deem;
    end
  end

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      int e_bb;
      e_bb = m_par ? m_pbb : m_bb;
      check_eq("R2 att_target", att_target, m_par ? 127 : m_att);
      check_eq("R3 bass_mode", bass_mode, e_bb);
      check_eq("R3 deemph_on", deemph_on, m_par ? m_pdeem : m_deem);
      check_eq("R5 out_l_src", out_l_src, (!m_par && m_mono) ? m_csel : 0);
      check_eq("R5 out_r_src", out_r_src, (!m_par && m_mono) ? m_csel : 1);
      check_eq("R6 boost_active", boost_active, e_bb != 0);
    end
  end

  task automatic shift_word(logic [7:0] w);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) host_dat = w[i];
      repeat (3) @(negedge clk);
      host_clk = 1'b1;
      repeat (3) @(negedge clk);
      host_clk = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_latch();
    host_lat = 1'b1;
    repeat (3) @(negedge clk);
    host_lat = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic send_word(logic [7:0] w);
    shift_word(w);
    pulse_latch();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R9 reset att", att_target, 127);
    check_eq("R9 reset bass", bass_mode, 0);
    check_eq("R9 reset deemph", deemph_on, 0);
    check_eq("R9 reset left src", out_l_src, 0);
    check_eq("R9 reset right src", out_r_src, 1);
    cmp_on = 1'b1;

    shift_word(8'h35);
    check_eq("R1 no latch no change", att_target, 127);
    pulse_latch();
    check_eq("R2 att load", att_target, 8'h35);
    check_eq("R1 bit order", att_target, 53);

    send_word(8'hF6);
    check_eq("R3 bass", bass_mode, 2);
    check_eq("R3 deemph", deemph_on, 1);
    check_eq("R3 reserved ignored left", out_l_src, 0);
    check_eq("R3 reserved ignored right", out_r_src, 1);
    check_eq("R4 att kept", att_target, 53);

    send_word(8'h00);
    check_eq("R2 att zero", att_target, 0);
    check_eq("R4 mode kept", bass_mode, 2);

    send_word(8'h98);
    check_eq("R5 mono right L", out_l_src, 1);
    check_eq("R5 mono right R", out_r_src, 1);
    check_eq("R6 flat", boost_active, 0);

    send_word(8'h88);
    check_eq("R5 mono left L", out_l_src, 0);
    check_eq("R5 mono left R", out_r_src, 0);

    send_word(8'h81);
    check_eq("R6 boost on", boost_active, 1);
    check_eq("R5 stereo R", out_r_src, 1);

    send_word(8'h98);
    par_sel = 1'b1; pin_bb = 2'b11; pin_deem = 1'b1;
    repeat (2) @(negedge clk);
    check_eq("R7 par att", att_target, 127);
    check_eq("R7 par bass", bass_mode, 3);
    check_eq("R7 par deemph", deemph_on, 1);
    check_eq("R7 par stereo L", out_l_src, 0);
    check_eq("R7 par stereo R", out_r_src, 1);
    send_word(8'h12);
    check_eq("R7 serial ignored", att_target, 127);
    pin_bb = 2'b00;
    repeat (2) @(negedge clk);
    check_eq("R7 par flat", boost_active, 0);

    par_sel = 1'b0;
    repeat (2) @(negedge clk);
    check_eq("R8 stored att", att_target, 8'h12);
    check_eq("R8 stored mono L", out_l_src, 1);
    check_eq("R8 stored bass", bass_mode, 0);

    shift_word(8'h5A);
    host_lat = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_eq("R10 not yet", att_target, 8'h12);
    @(negedge clk);
    check_eq("R10 visible", att_target, 8'h5A);
    repeat (2) @(negedge clk);
    host_lat = 1'b0;
    repeat (6) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule